// File: doc/BRIEF.md
# Power-Good Supervisor with Asymmetric Qualification

This block watches one regulated supply rail and decides whether it is good. Two analog comparators outside the block feed it: one flag is high while the rail sits above the upper threshold (94 % of nominal), the other is high while the rail sits below the lower threshold (90 % of nominal). Between the two thresholds neither flag is set, which gives the monitor its hysteresis. Only the second regulator channel is supervised, so the block takes that channel's enable.

Declaring the rail good takes a long, unbroken run of "above upper threshold" samples. Withdrawing good takes only a short, unbroken run of "below lower threshold" samples. Both windows come from one timing setting. The exit window is set in clock cycles, and the entry window is that value times a fixed ratio. The default ratio is 8000, which matches a 200 ms entry against a 25 µs exit. A minimum exit window (10 µs worth of cycles) is enforced when the design is elaborated.

The output models an open-drain, active-low reset pin. A drive-enable is high while the pin must be pulled low, that is while the rail is not good. The pull-up is external. The reset input is asynchronous active-low and must be released synchronously to the clock.

Top module: `pgood_supervisor`

## Requirements
- R1: While reset is asserted and after its release, `pgood_o` is 0 and `pin_low_en_o` is 1.
- R2: With the channel enabled and not good, `pgood_o` becomes 1 at the clock edge that samples the Nth consecutive high value of `above_hi_i`, where N = EXIT_CYC * ENTRY_RATIO. It is 0 after every earlier edge.
- R3: A single low sample of `above_hi_i` during the entry window restarts the run, so N fresh consecutive high samples are then needed.
- R4: With the channel enabled and good, `pgood_o` becomes 0 at the edge that samples the EXIT_CYC-th consecutive high value of `below_lo_i`. It stays 1 after every earlier edge.
- R5: A single low sample of `below_lo_i` during the exit window restarts the run, so EXIT_CYC fresh consecutive high samples are then needed.
- R6: Hysteresis: while good, a rail between thresholds (both flags 0) keeps `pgood_o` at 1 for any length of time. While not good, `below_lo_i` has no effect and a rail between thresholds does not count toward entry.
- R7: `chan_en_i` sampled low forces `pgood_o` to 0 at that edge and clears both windows. After re-enable, a full N-sample entry run is needed, even if `above_hi_i` was high before.
- R8: `pin_low_en_o` is always the inverse of `pgood_o`: 1 means the pin is driven low, 0 means the pin is released.
- R9: The entry window is exactly EXIT_CYC * ENTRY_RATIO cycles. A configuration with EXIT_CYC below MIN_EXIT_CYC, or with ENTRY_RATIO below 1, fails elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chan_en_i | input | 1 | Enable of the supervised regulator channel |
| above_hi_i | input | 1 | Comparator flag: rail above the upper (94 %) threshold |
| below_lo_i | input | 1 | Comparator flag: rail below the lower (90 %) threshold |
| pgood_o | output | 1 | Qualified power-good state |
| pin_low_en_o | output | 1 | Drive-enable of the open-drain pin; 1 pulls the reset pin low |

## Verification
A window counter that is stuck or off by one moves the edge at which `pgood_o` changes. The bench sweeps every run length around both windows and checks the output after each cycle, so such a fault shows within one cycle of the expected edge. A counter that fails to restart shows up as an early transition in the interruption sweeps, where the gap is placed at every position of the window. Leftover state across a disable shows up as a premature rise after re-enable. A state register that does not clear shows on the very next cycle after `chan_en_i` falls.

// File: rtl/pgsup_pkg.sv
package pgsup_pkg;

  typedef enum logic {
    PG_BAD = 1'b0,
    PG_OK  = 1'b1
  } pg_state_e;

  // counter width able to hold values 0 .. len-1
  function automatic int unsigned win_width(input int unsigned len);
    return (len > 1) ? $clog2(len) : 1;
  endfunction

endpackage

// File: rtl/pgsup_window.sv
// Qualification window: asserts hit on the edge that samples the LEN-th
// consecutive qualifying cycle; any break or disarm restarts from zero.
module pgsup_window
  import pgsup_pkg::*;
#(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cond,
  output logic hit
);

  localparam int unsigned CW   = win_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          run;

  always_comb begin
    run    = arm & cond;
    hit    = run && (cnt_q == LAST);
    cnt_en = run || (cnt_q != '0);
    if (run && !hit) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R3/R5: the run length never passes the window length
  assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7: a disarmed window holds no partial run
  assert_window_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (cnt_q == '0));

endmodule

// File: rtl/pgsup_state.sv
// Two-state power-good register with disable override.
module pgsup_state
  import pgsup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic entry_hit,
  input  logic exit_hit,
  output logic pgood
);

  pg_state_e state_q;
  pg_state_e state_d;
  logic      state_en;

  always_comb begin
    state_d = state_q;
    if (!chan_en) begin
      state_d = PG_BAD;
    end else begin
      case (state_q)
        PG_BAD:  if (entry_hit) state_d = PG_OK;
        PG_OK:   if (exit_hit)  state_d = PG_BAD;
        default: state_d = PG_BAD;
      endcase
    end
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_BAD;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign pgood = (state_q == PG_OK);

  // R2/R4: the state only changes on a qualified window or a disable
  assert_change_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> ($past(entry_hit) || $past(exit_hit) || !$past(chan_en)));

endmodule

// File: rtl/pgood_supervisor.sv
// Power-good supervisor for one regulator rail with long entry / short exit
// qualification and open-drain active-low output modelled as a drive-enable.
module pgood_supervisor
  import pgsup_pkg::*;
#(
  parameter int unsigned EXIT_CYC     = 25,
  parameter int unsigned ENTRY_RATIO  = 8000,
  parameter int unsigned MIN_EXIT_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en_i,
  input  logic above_hi_i,
  input  logic below_lo_i,
  output logic pgood_o,
  output logic pin_low_en_o
);

  localparam int unsigned ENTRY_CYC = EXIT_CYC * ENTRY_RATIO;

  // R9: configuration limits
  generate
    if (EXIT_CYC < MIN_EXIT_CYC) begin : g_exit_too_short
      $error("pgood_supervisor: EXIT_CYC below MIN_EXIT_CYC");
    end
    if (ENTRY_RATIO < 1) begin : g_ratio_invalid
      $error("pgood_supervisor: ENTRY_RATIO must be at least 1");
    end
  endgenerate

  logic pgood;
  logic arm_entry;
  logic arm_exit;
  logic entry_hit;
  logic exit_hit;

  always_comb begin
    arm_entry = chan_en_i & ~pgood;
    arm_exit  = chan_en_i &  pgood;
  end

  pgsup_window #(.LEN(ENTRY_CYC)) u_entry_win (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm_entry),
    .cond  (above_hi_i),
    .hit   (entry_hit)
  );

  pgsup_window #(.LEN(EXIT_CYC)) u_exit_win (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm_exit),
    .cond  (below_lo_i),
    .hit   (exit_hit)
  );

  pgsup_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en_i),
    .entry_hit (entry_hit),
    .exit_hit  (exit_hit),
    .pgood     (pgood)
  );

  assign pgood_o      = pgood;
  assign pin_low_en_o = ~pgood;

  // R2: good is only entered on a cycle where the rail was above threshold
  assert_rise_after_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> ($past(above_hi_i) && $past(chan_en_i)));

  // R4: good is only left after a low-rail sample or a disable
  assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgood_o) |-> ($past(below_lo_i) || !$past(chan_en_i)));

  // R6: a rail inside the hysteresis band keeps good
  assert_hold_in_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood_o && chan_en_i && !below_lo_i) |=> pgood_o);

  // R7: disable forces the pin low on the next cycle
  assert_disable_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en_i |=> (!pgood_o && pin_low_en_o));

endmodule

// File: tb/pgood_supervisor_tb.sv
module pgood_supervisor_tb_top;

  localparam int unsigned EXIT_CYC    = 3;
  localparam int unsigned ENTRY_RATIO = 4;
  localparam int unsigned MIN_EXIT    = 2;
  localparam int unsigned NENT        = EXIT_CYC * ENTRY_RATIO;
  localparam int unsigned NEX         = EXIT_CYC;

  logic clk;
  logic rst_n;
  logic chan_en;
  logic above_hi;
  logic below_lo;
  logic pgood;
  logic pin_low_en;

  int total;
  int bad;

  pgood_supervisor #(
    .EXIT_CYC     (EXIT_CYC),
    .ENTRY_RATIO  (ENTRY_RATIO),
    .MIN_EXIT_CYC (MIN_EXIT)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .chan_en_i    (chan_en),
    .above_hi_i   (above_hi),
    .below_lo_i   (below_lo),
    .pgood_o      (pgood),
    .pin_low_en_o (pin_low_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R8 is checked with every call: pin drive-enable must be the inverse
  task automatic chk(input logic exp_g, input string req);
    total++;
    if (pgood !== exp_g || pin_low_en !== ~exp_g) begin
      bad++;
      $display("FAIL %s: pgood=%0b pin_low_en=%0b expected pgood=%0b pin_low_en=%0b (R8)",
               req, pgood, pin_low_en, exp_g, ~exp_g);
    end
  endtask

  // clear to not-good through a one-cycle disable (R7)
  task automatic clear_low();
    chan_en = 1'b0; above_hi = 1'b0; below_lo = 1'b0;
    step(1);
    chan_en = 1'b1;
  endtask

  task automatic go_good();
    clear_low();
    above_hi = 1'b1;
    step(NENT);
    chk(1'b1, "R2 setup");
    above_hi = 1'b0;
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; chan_en = 1'b1; above_hi = 1'b1; below_lo = 1'b0;
    step(NENT + 3);
    chk(1'b0, "R1 during reset");
    rst_n = 1'b1;
    above_hi = 1'b0;
    step(1);
    chk(1'b0, "R1 after release");

    // R2/R9: entry sweep over every run length around the window
    for (int len = 1; len <= int'(NENT) + 2; len++) begin
      clear_low();
      above_hi = 1'b1;
      for (int i = 1; i <= len; i++) begin
        step(1);
        chk(i >= int'(NENT), (i == int'(NENT)) ? "R9 entry length" : "R2 entry sweep");
      end
      above_hi = 1'b0;
    end

    // R3: a one-cycle gap at every position restarts the entry run
    for (int g = 1; g < int'(NENT); g++) begin
      clear_low();
      above_hi = 1'b1;
      step(g);
      above_hi = 1'b0;
      step(1);
      chk(1'b0, "R3 gap");
      above_hi = 1'b1;
      step(NENT - 1);
      chk(1'b0, "R3 restart short");
      step(1);
      chk(1'b1, "R3 restart full");
      above_hi = 1'b0;
    end

    // R4: exit sweep
    for (int len = 1; len <= int'(NEX) + 1; len++) begin
      go_good();
      below_lo = 1'b1;
      for (int i = 1; i <= len; i++) begin
        step(1);
        chk(i < int'(NEX), "R4 exit sweep");
      end
      below_lo = 1'b0;
    end

    // R5: a gap at every position restarts the exit run
    for (int g = 1; g < int'(NEX); g++) begin
      go_good();
      below_lo = 1'b1;
      step(g);
      below_lo = 1'b0;
      step(1);
      chk(1'b1, "R5 gap");
      below_lo = 1'b1;
      step(NEX - 1);
      chk(1'b1, "R5 restart short");
      step(1);
      chk(1'b0, "R5 restart full");
      below_lo = 1'b0;
    end

    // R6: hysteresis band holds either state
    go_good();
    step(50);
    chk(1'b1, "R6 band holds good");
    clear_low();
    below_lo = 1'b1;
    step(NEX + 5);
    chk(1'b0, "R6 low flag ignored while bad");
    below_lo = 1'b0;
    step(50);
    chk(1'b0, "R6 band holds bad");
    above_hi = 1'b1;
    step(NENT - 1);
    chk(1'b0, "R6 band cycles not counted");
    step(1);
    chk(1'b1, "R6 entry after band");
    above_hi = 1'b0;

    // R7: disable while good, then re-enable with rail already high
    go_good();
    above_hi = 1'b1;
    chan_en = 1'b0;
    step(1);
    chk(1'b0, "R7 disable drops good");
    chan_en = 1'b1;
    step(NENT - 1);
    chk(1'b0, "R7 full window after re-enable");
    step(1);
    chk(1'b1, "R7 good after full window");

    // R7: disable mid-window clears the partial run
    clear_low();
    above_hi = 1'b1;
    step(NENT - 1);
    chk(1'b0, "R7 partial run");
    chan_en = 1'b0;
    step(1);
    chk(1'b0, "R7 disabled");
    chan_en = 1'b1;
    step(NENT - 1);
    chk(1'b0, "R7 partial run cleared");
    step(1);
    chk(1'b1, "R7 good after fresh run");
    above_hi = 1'b0;

    // R1: reset while good
    rst_n = 1'b0;
    step(1);
    chk(1'b0, "R1 reset while good");
    rst_n = 1'b1;
    step(1);
    chk(1'b0, "R1 after second release");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule